// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of four channel requests is serviced next and runs the bus hand-over with the host processor. Request inputs pass through a programmable polarity correction and then through per-channel masks. Software request bits join them and are not masked. When any qualified request is pending and the controller is enabled, the arbiter raises a hold request. It waits for the host's hold acknowledge, picks a winner by fixed or rotating priority, and then drives one acknowledge line with programmable polarity, together with the winner's index.

A service period ends according to the winning channel's transfer mode. The external datapath reports each moved byte on `xfer_done` and the end of a whole transfer on `eop`. After a service ends, the arbiter drops hold request. It then waits for the host to drop hold acknowledge before it arbitrates again. Configuration arrives through a single-cycle write port: a register address and a data byte.

Top module: `dma_arb_top`

## Requirements
- R1: After reset all four masks are set and the command byte is zero. With every request line active, `hold_req` stays 0, `dack` idles at 4'hF (active-low acknowledge), and `grant_idx` is 0.
- R2: Command byte (address 0) bit 6 = 1 makes the request lines active-low; 0 makes them active-high.
- R3: Command byte bit 7 = 1 makes `dack` active-high; with 0 it is active-low. When no channel is in service, `dack` holds the inactive level.
- R4: A pending qualified request raises `hold_req` within a few cycles. `dack` changes only in the cycle after `hold_ack` is seen high. `grant_idx` then names the winner.
- R5: When command bit 4 = 0 (fixed priority), the lowest-numbered pending channel wins.
- R6: When command bit 4 = 1 (rotating priority), the channel just serviced becomes lowest. Priority then runs upward from the next channel, so after channel 2 is serviced, channel 3 beats channel 0.
- R7: Writes to the mask registers: address 2, data {bit2 = set/clear, [1:0] = channel}, changes one mask. Address 6 loads all masks from data[3:0]. Address 5 clears all masks. Address 4 is a master clear, which restores the reset state and sets all masks. A masked hardware request never raises hold.
- R8: Command bit 5 = 1 disables the controller. It then never raises `hold_req`.
- R9: Single mode (mode register at address 3, data {[3:2] = mode, [1:0] = channel}, mode 01) ends service on each `xfer_done`. If the request is still active, the arbiter requests hold again after `hold_ack` falls.
- R10: Block mode (mode 10 or 11) keeps hold and the acknowledge through `xfer_done` pulses and through request loss. It ends only on `eop`.
- R11: Demand mode (mode 00, the reset value) ends service on `eop`, or on `xfer_done` when the channel's request is no longer pending.
- R12: A software request (address 3 is taken; address 1, data {bit2 = set/clear, [1:0] = channel}) counts as pending even when the channel is masked. It is cleared when that channel's service ends.
- R13: The rotation pointer changes only at the end of a service period, never in the middle of one.
- R14: `req_status` shows every request line after polarity correction, whatever the masks are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| req_in | input | 4 | Raw channel request lines |
| hold_ack | input | 1 | Host grants the bus |
| eop | input | 1 | End of whole transfer |
| xfer_done | input | 1 | One byte moved |
| hold_req | output | 1 | Bus hold request to the host |
| dack | output | 4 | Per-channel acknowledge, programmable polarity |
| grant_idx | output | 2 | Index of the channel last granted |
| req_status | output | 4 | Polarity-corrected request lines |

## Verification
A corrupted rotation pointer shows up at the next arbitration as a wrong `grant_idx` and a wrong `dack` line, one cycle after `hold_ack`. A wrong mask or software request bit shows as `hold_req` rising, or staying low, within two cycles of the request. A mode decode error shows up on the very `xfer_done` or `eop` cycle: `hold_req` either falls in the following cycle when it should not, or fails to fall when it should. Polarity faults show at once on `req_status` and on the idle level of `dack`.

// File: rtl/dma_arb_pkg.sv
// Shared types for the DMA request arbiter.
// Assumes a write port with 4-bit addresses and 8-bit data.
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SERVE = 2'd2,
        ST_REL = 2'd3
    } arb_state_t;

    localparam logic [1:0] MODE_DEMAND = 2'b00;
    localparam logic [1:0] MODE_SINGLE = 2'b01;

    localparam logic [3:0] ADR_CMD     = 4'd0;
    localparam logic [3:0] ADR_SWREQ   = 4'd1;
    localparam logic [3:0] ADR_MASK1   = 4'd2;
    localparam logic [3:0] ADR_MODE    = 4'd3;
    localparam logic [3:0] ADR_MCLR    = 4'd4;
    localparam logic [3:0] ADR_UNMASK  = 4'd5;
    localparam logic [3:0] ADR_MASKALL = 4'd6;
endpackage

// File: rtl/dma_arb_regs.sv
// Configuration registers: command bits, masks, per-channel modes and
// software requests. Assumes NCH is a power of two and at most 4, so that
// a channel number fits in data[1:0] and a mask vector fits in data[3:0].
module dma_arb_regs
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 svc_end,
    input  logic [CW-1:0]        svc_ch,
    output logic                 mclr,
    output logic                 ctl_dis,
    output logic                 rot_en,
    output logic                 req_lo,
    output logic                 ack_hi,
    output logic [NCH-1:0]       mask_q,
    output logic [NCH-1:0]       swreq_q,
    output logic [NCH-1:0][1:0]  mode_q
);
    logic [CW-1:0] wr_ch;

    // Decode the master clear strobe and the addressed channel.
    always_comb begin
        mclr  = wr_en && (wr_addr == ADR_MCLR);
        wr_ch = wr_data[CW-1:0];
    end

    // Command bits.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            ctl_dis <= 1'b0;
            rot_en  <= 1'b0;
            req_lo  <= 1'b0;
            ack_hi  <= 1'b0;
        end else if (wr_en && wr_addr == ADR_CMD) begin
            ctl_dis <= wr_data[5];
            rot_en  <= wr_data[4];
            req_lo  <= wr_data[6];
            ack_hi  <= wr_data[7];
        end
    end

    // Channel masks: single-bit, whole-vector and clear-all writes.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mask_q <= '1;
        end else if (wr_en && wr_addr == ADR_MASK1) begin
            mask_q[wr_ch] <= wr_data[2];
        end else if (wr_en && wr_addr == ADR_MASKALL) begin
            mask_q <= wr_data[NCH-1:0];
        end else if (wr_en && wr_addr == ADR_UNMASK) begin
            mask_q <= '0;
        end
    end

    // Per-channel transfer modes.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mode_q <= '0;
        end else if (wr_en && wr_addr == ADR_MODE) begin
            mode_q[wr_ch] <= wr_data[3:2];
        end
    end

    // Software requests: cleared at the end of that channel's service.
    // A write in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            swreq_q <= '0;
        end else begin
            if (svc_end) swreq_q[svc_ch] <= 1'b0;
            if (wr_en && wr_addr == ADR_SWREQ) swreq_q[wr_ch] <= wr_data[2];
        end
    end

    AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (&mask_q && swreq_q == '0)); // R7
endmodule

// File: rtl/dma_arb_prio.sv
// Combinational priority pick over the pending vector. In fixed mode the
// search starts at channel 0. In rotating mode it starts one above the
// last serviced channel. Assumes NCH is a power of two, so the index wraps
// naturally.
module dma_arb_prio #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] pend,
    input  logic           rot_en,
    input  logic [CW-1:0]  last_ch,
    output logic [CW-1:0]  win_ch,
    output logic           any_pend
);
    logic [CW-1:0] base;
    logic [CW-1:0] idx;
    logic          found;

    // Walk the channels from the highest-priority one and take the first hit.
    always_comb begin
        base   = rot_en ? CW'(last_ch + 1'b1) : '0;
        win_ch = '0;
        found  = 1'b0;
        idx    = '0;
        for (int i = 0; i < NCH; i++) begin
            idx = CW'(base + CW'(i));
            if (!found && pend[idx]) begin
                win_ch = idx;
                found  = 1'b1;
            end
        end
        any_pend = found;
    end
endmodule

// File: rtl/dma_arb_fsm.sv
// Hold handshake and service-period control. It raises the hold request
// and latches the winner when hold_ack arrives. It ends the service by the
// winner's mode and waits for hold_ack to fall before arbitrating again.
// Assumes the host keeps hold_ack high while hold_req is high.
module dma_arb_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mclr,
    input  logic                ctl_dis,
    input  logic                hold_ack,
    input  logic                eop,
    input  logic                xfer_done,
    input  logic [NCH-1:0]      pend,
    input  logic [NCH-1:0][1:0] mode_q,
    input  logic                any_pend,
    input  logic [CW-1:0]       win_ch,
    output logic                hold_req,
    output logic [NCH-1:0]      dack_vec,
    output logic [CW-1:0]       gnt,
    output logic [CW-1:0]       last_ch,
    output logic                svc_end
);
    arb_state_t st;
    logic [1:0] mode_g;

    // Decide whether the current service period ends this cycle.
    always_comb begin
        mode_g  = mode_q[gnt];
        svc_end = (st == ST_SERVE) &&
                  (eop || (xfer_done && (mode_g == MODE_SINGLE ||
                                         (mode_g == MODE_DEMAND && !pend[gnt]))));
    end

    // State sequencing, winner latch and rotation pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            st      <= ST_IDLE;
            gnt     <= '0;
            last_ch <= CW'(NCH - 1);
        end else begin
            case (st)
                ST_IDLE:  if (!ctl_dis && any_pend) st <= ST_WAIT;
                ST_WAIT: begin
                    if (!any_pend || ctl_dis) begin
                        st <= ST_IDLE;
                    end else if (hold_ack) begin
                        st  <= ST_SERVE;
                        gnt <= win_ch;
                    end
                end
                ST_SERVE: begin
                    if (svc_end) begin
                        st      <= ST_REL;
                        last_ch <= gnt;
                    end
                end
                default:  if (!hold_ack) st <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        hold_req = (st == ST_WAIT) || (st == ST_SERVE);
        dack_vec = '0;
        if (st == ST_SERVE) dack_vec[gnt] = 1'b1;
    end

    AST_ACK_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dack_vec) |-> $past(hold_ack)); // R4
    AST_DIS_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ctl_dis) |=> !hold_req); // R8
    AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !svc_end && !mclr) |=> $stable(last_ch)); // R13
    AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SERVE && mode_g[1] && !eop && !mclr) |=> (st == ST_SERVE && $stable(gnt))); // R10
    AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SERVE && mode_g == MODE_SINGLE && xfer_done) |=> !hold_req); // R9
    AST_DEMAND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SERVE && mode_g == MODE_DEMAND && xfer_done && !pend[gnt]) |=> !hold_req); // R11
endmodule

// File: rtl/dma_arb_top.sv
// DMA request priority arbiter: polarity correction, masking, priority
// pick and the hold handshake. The datapath reports bytes on xfer_done and
// transfer ends on eop. Assumes NCH = 4 with the write-port field layout
// of the register block.
module dma_arb_top #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     wr_addr,
    input  logic [7:0]     wr_data,
    input  logic [NCH-1:0] req_in,
    input  logic           hold_ack,
    input  logic           eop,
    input  logic           xfer_done,
    output logic           hold_req,
    output logic [NCH-1:0] dack,
    output logic [CW-1:0]  grant_idx,
    output logic [NCH-1:0] req_status
);
    logic                mclr, ctl_dis, rot_en, req_lo, ack_hi;
    logic [NCH-1:0]      mask_q, swreq_q, pend, dack_vec;
    logic [NCH-1:0][1:0] mode_q;
    logic [CW-1:0]       win_ch, last_ch;
    logic                any_pend, svc_end;

    dma_arb_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .svc_end(svc_end), .svc_ch(grant_idx),
        .mclr(mclr), .ctl_dis(ctl_dis), .rot_en(rot_en), .req_lo(req_lo),
        .ack_hi(ack_hi), .mask_q(mask_q), .swreq_q(swreq_q), .mode_q(mode_q)
    );

    // Correct request polarity and qualify with masks and software requests.
    always_comb begin
        req_status = req_in ^ {NCH{req_lo}};
        pend       = (req_status & ~mask_q) | swreq_q;
    end

    dma_arb_prio #(.NCH(NCH)) u_prio (
        .pend(pend), .rot_en(rot_en), .last_ch(last_ch),
        .win_ch(win_ch), .any_pend(any_pend)
    );

    dma_arb_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .ctl_dis(ctl_dis),
        .hold_ack(hold_ack), .eop(eop), .xfer_done(xfer_done), .pend(pend),
        .mode_q(mode_q), .any_pend(any_pend), .win_ch(win_ch),
        .hold_req(hold_req), .dack_vec(dack_vec), .gnt(grant_idx),
        .last_ch(last_ch), .svc_end(svc_end)
    );

    // Apply acknowledge polarity.
    always_comb dack = ack_hi ? dack_vec : ~dack_vec;

    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req && pend == '0) |=> !hold_req); // R7
endmodule

// File: tb/dma_arb_top_bench.sv
module dma_arb_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] req_in = '0;
    logic       hold_ack = 1'b0;
    logic       eop = 1'b0;
    logic       xfer_done = 1'b0;
    logic       hold_req;
    logic [3:0] dack;
    logic [1:0] grant_idx;
    logic [3:0] req_status;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_arb_top u_dma_arb_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_in(req_in), .hold_ack(hold_ack), .eop(eop),
        .xfer_done(xfer_done), .hold_req(hold_req), .dack(dack),
        .grant_idx(grant_idx), .req_status(req_status)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for hold, check the idle acknowledge, grant the bus, check the winner.
    task automatic serve_start(input string tag, input logic [1:0] ch,
                               input logic [3:0] idle_lvl, input logic [3:0] act_lvl);
        for (int i = 0; i < 8 && !hold_req; i++) @(negedge clk);
        chk({tag, " R4 hold_req"}, {7'd0, hold_req}, 8'd1);
        chk({tag, " R4 no dack before ack"}, {4'd0, dack}, {4'd0, idle_lvl});
        hold_ack = 1'b1;
        @(negedge clk);
        chk({tag, " grant"}, {6'd0, grant_idx}, {6'd0, ch});
        chk({tag, " dack"}, {4'd0, dack}, {4'd0, act_lvl});
    endtask

    // End the service with eop or xfer_done and hand the bus back.
    task automatic serve_end(input string tag, input logic use_eop);
        if (use_eop) eop = 1'b1; else xfer_done = 1'b1;
        @(negedge clk);
        eop = 1'b0; xfer_done = 1'b0;
        chk({tag, " hold released"}, {7'd0, hold_req}, 8'd0);
        hold_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        req_in = 4'hF;
        idle_wait(3);
        rst_n = 1'b1;
        idle_wait(3);
        chk("R1 hold_req", {7'd0, hold_req}, 8'd0);
        chk("R1 dack idle", {4'd0, dack}, 8'h0F);
        chk("R1 grant", {6'd0, grant_idx}, 8'd0);
        chk("R14 status", {4'd0, req_status}, 8'h0F);
    endtask

    task automatic t_fixed();
        wr(4'd4, 8'h00);
        req_in = 4'b1010;
        wr(4'd5, 8'h00);
        serve_start("R5 fixed", 2'd1, 4'hF, 4'b1101);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R11 demand keeps hold", {7'd0, hold_req}, 8'd1);
        req_in = 4'b1000;
        serve_end("R11 demand req drop", 1'b0);
        serve_start("R5 next", 2'd3, 4'hF, 4'b0111);
        serve_end("R11 demand eop", 1'b1);
        req_in = 4'b0000;
        idle_wait(2);
    endtask

    task automatic t_rotate();
        wr(4'd4, 8'h00);
        wr(4'd0, 8'h10);
        for (int c = 0; c < 4; c++) wr(4'd3, 8'(4 | c));
        wr(4'd5, 8'h00);
        req_in = 4'hF;
        for (int k = 0; k < 5; k++) begin
            serve_start("R6 R9 R13 rotate", 2'(k % 4), 4'hF, ~(4'b0001 << (k % 4)));
            serve_end("R9 single", 1'b0);
        end
        req_in = 4'b0100;
        serve_start("R6 serve two", 2'd2, 4'hF, 4'b1011);
        req_in = 4'b1001;
        serve_end("R9 single", 1'b0);
        serve_start("R6 three after two", 2'd3, 4'hF, 4'b0111);
        serve_end("R9 single", 1'b0);
        wr(4'd0, 8'h00);
        req_in = 4'hF;
        serve_start("R5 fixed repeat a", 2'd0, 4'hF, 4'b1110);
        serve_end("R9 single", 1'b0);
        serve_start("R5 fixed repeat b", 2'd0, 4'hF, 4'b1110);
        req_in = 4'h0;
        serve_end("R9 single", 1'b0);
        idle_wait(2);
    endtask

    task automatic t_disable();
        wr(4'd4, 8'h00);
        wr(4'd0, 8'h20);
        wr(4'd5, 8'h00);
        req_in = 4'b0001;
        idle_wait(5);
        chk("R8 disabled no hold", {7'd0, hold_req}, 8'd0);
        wr(4'd0, 8'h00);
        serve_start("R8 enabled", 2'd0, 4'hF, 4'b1110);
        req_in = 4'h0;
        serve_end("R8", 1'b1);
        idle_wait(2);
    endtask

    task automatic t_polarity();
        wr(4'd4, 8'h00);
        wr(4'd0, 8'hC0);
        req_in = 4'b1011;
        @(negedge clk);
        chk("R2 R14 active-low status", {4'd0, req_status}, 8'h04);
        chk("R3 idle active-high dack", {4'd0, dack}, 8'h00);
        wr(4'd3, 8'h06);
        wr(4'd5, 8'h00);
        serve_start("R2 R3 polarity", 2'd2, 4'h0, 4'b0100);
        req_in = 4'hF;
        serve_end("R9 single", 1'b0);
        idle_wait(3);
        chk("R2 no request when lines high", {7'd0, hold_req}, 8'd0);
    endtask

    task automatic t_masks();
        wr(4'd4, 8'h00);
        req_in = 4'b1110;
        idle_wait(4);
        chk("R7 master clear masks", {7'd0, hold_req}, 8'd0);
        wr(4'd6, 8'h0E);
        idle_wait(4);
        chk("R7 mask all write", {7'd0, hold_req}, 8'd0);
        wr(4'd3, 8'h06);
        wr(4'd2, 8'h02);
        serve_start("R7 single unmask", 2'd2, 4'hF, 4'b1011);
        wr(4'd2, 8'h06);
        serve_end("R9 single", 1'b0);
        idle_wait(4);
        chk("R7 single mask set", {7'd0, hold_req}, 8'd0);
        wr(4'd5, 8'h00);
        serve_start("R7 clear all", 2'd1, 4'hF, 4'b1101);
        req_in = 4'h0;
        serve_end("R11", 1'b1);
        idle_wait(2);
    endtask

    task automatic t_block();
        wr(4'd4, 8'h00);
        wr(4'd3, 8'h08);
        wr(4'd5, 8'h00);
        req_in = 4'b0001;
        serve_start("R10 block", 2'd0, 4'hF, 4'b1110);
        req_in = 4'b0000;
        for (int i = 0; i < 3; i++) begin
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            chk("R10 hold kept", {7'd0, hold_req}, 8'd1);
            chk("R10 dack kept", {4'd0, dack}, 8'h0E);
        end
        serve_end("R10 eop", 1'b1);
        idle_wait(2);
    endtask

    task automatic t_swreq();
        wr(4'd4, 8'h00);
        req_in = 4'b0000;
        wr(4'd1, 8'h07);
        serve_start("R12 software", 2'd3, 4'hF, 4'b0111);
        serve_end("R12", 1'b1);
        idle_wait(4);
        chk("R12 cleared after service", {7'd0, hold_req}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_rotate();
        t_disable();
        t_polarity();
        t_masks();
        t_block();
        t_swreq();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule